// File: doc/BRIEF.md
# Score-Replacement Translation Cache

This block caches linear-to-physical page translations in a set-associative array. A lookup presents a linear address and receives, in the same cycle, a hit flag and the translated physical address. After a page walk elsewhere has resolved a miss, the walker writes the result in through the fill port. Each fill gives the page size (4 KB, 2 MB or 4 MB) and states whether the mapping is global. Each entry keeps its own size mask, so pages of different sizes can share a set.

Each entry carries an 8-bit usage score. The score rises on every hit and stops at its ceiling. When a fill needs a slot, the cache first takes an empty way in the set. If there is none, it evicts the way with the least use. Three maintenance operations clear entries: a full flush, a flush that spares global mappings, and an invalidate of one page. Seven 64-bit event counters keep a running total of lookups, hits, misses, fills and each kind of maintenance request.

Top module: `score_tlb`

## Requirements
- R1: The set is chosen by linear address bits [12 +: log2(SETS)]. A lookup hits when some way of that set is valid and the lookup address ANDed with that way's mask equals its tag. `lk_hit` and `lk_paddr` respond in the same cycle as `lk_valid`.
- R2: On a hit, `lk_paddr` is the stored base (fill physical address ANDed with the mask) ORed with the lookup address bits that the mask clears.
- R3: `up_size` encodes the page size: 0 is 4 KB (mask clears bits 11:0), 1 is 2 MB (clears 20:0), 2 is 4 MB (clears 21:0), and 3 is treated as 4 KB. The tag is the fill address ANDed with the mask.
- R4: A fill goes into the lowest-numbered invalid way of the indexed set if one exists.
- R5: When every way of the set is valid, the fill evicts the way with the smallest score. Equal scores go to the lowest way number.
- R6: A fill sets the entry's score to 0. Each hit adds 1 to the hit entry's score, which saturates at 255 and never wraps.
- R7: `fl_all` invalidates every entry, including one filled in the same cycle.
- R8: `fl_nonglobal` invalidates every entry whose global flag is clear and leaves global entries usable.
- R9: `inv_valid` invalidates every entry of the set indexed by `inv_laddr` that would hit on `inv_laddr`, whether global or not. This includes an entry filled in the same cycle.
- R10: When a lookup and a fill occur in the same cycle, the lookup sees the contents from before the fill. The victim is chosen from the scores as they stood at the start of the cycle. If the hit way is also the victim, the fill wins and its score is 0.
- R11: The counters `cnt_lookup`, `cnt_hit`, `cnt_miss`, `cnt_update`, `cnt_fl_all`, `cnt_fl_nonglobal` and `cnt_inv` each add one for every cycle in which their event occurs.
- R12: After reset every entry is invalid and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | AW | Lookup linear address |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_paddr | output | AW | Translated physical address |
| up_valid | input | 1 | Fill request |
| up_laddr | input | AW | Fill linear address |
| up_paddr | input | AW | Fill physical address |
| up_size | input | 2 | Fill page size code |
| up_global | input | 1 | Fill mapping is global |
| fl_all | input | 1 | Invalidate all entries |
| fl_nonglobal | input | 1 | Invalidate non-global entries |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_laddr | input | AW | Address of page to invalidate |
| cnt_lookup | output | CW | Lookup count |
| cnt_hit | output | CW | Hit count |
| cnt_miss | output | CW | Miss count |
| cnt_update | output | CW | Fill count |
| cnt_fl_all | output | CW | Full-flush count |
| cnt_fl_nonglobal | output | CW | Non-global flush count |
| cnt_inv | output | CW | Single-page invalidate count |

## Verification
A hit that raises a score can land in the same cycle as a fill into the same set. The bench arranges this by filling a set, raising three of its four scores, and then driving a lookup of the fourth way together with a new fill. The outcome is judged a cycle later by a second fill. With correct behaviour that fill evicts the same way again. If the dropped increment had leaked into the new entry, way 0 would be evicted instead. Fills that race a full flush or a page invalidate are judged by whether the page misses afterwards.

// File: rtl/score_tlb.sv
module score_tlb #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int AW   = 32,
  parameter int CW   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_laddr,
  output logic          lk_hit,
  output logic [AW-1:0] lk_paddr,
  input  logic          up_valid,
  input  logic [AW-1:0] up_laddr,
  input  logic [AW-1:0] up_paddr,
  input  logic [1:0]    up_size,
  input  logic          up_global,
  input  logic          fl_all,
  input  logic          fl_nonglobal,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_laddr,
  output logic [CW-1:0] cnt_lookup,
  output logic [CW-1:0] cnt_hit,
  output logic [CW-1:0] cnt_miss,
  output logic [CW-1:0] cnt_update,
  output logic [CW-1:0] cnt_fl_all,
  output logic [CW-1:0] cnt_fl_nonglobal,
  output logic [CW-1:0] cnt_inv
);
  localparam int IW = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [7:0] SC_MAX = 8'hFF;

  function automatic logic [AW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd1:    return {AW{1'b1}} << 21;
      2'd2:    return {AW{1'b1}} << 22;
      default: return {AW{1'b1}} << 12;
    endcase
  endfunction

  logic          v_q    [WAYS][SETS];
  logic          g_q    [WAYS][SETS];
  logic [7:0]    sc_q   [WAYS][SETS];
  logic [AW-1:0] tag_q  [WAYS][SETS];
  logic [AW-1:0] msk_q  [WAYS][SETS];
  logic [AW-1:0] base_q [WAYS][SETS];

  logic          fill_e [WAYS][SETS];
  logic          bump_e [WAYS][SETS];
  logic          drop_e [WAYS][SETS];

  logic [IW-1:0] lk_set, up_set, inv_set;
  logic [AW-1:0] up_mask;
  logic          hit_any;
  logic [WW-1:0] hit_way, vic;

  assign lk_set  = lk_laddr[12 +: IW];
  assign up_set  = up_laddr[12 +: IW];
  assign inv_set = inv_laddr[12 +: IW];
  assign up_mask = size_mask(up_size);
  assign lk_hit  = lk_valid & hit_any;

  always_comb begin
    hit_any  = 1'b0;
    hit_way  = '0;
    lk_paddr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (v_q[w][lk_set] && ((lk_laddr & msk_q[w][lk_set]) == tag_q[w][lk_set])) begin
        hit_any  = 1'b1;
        hit_way  = WW'(w);
        lk_paddr = base_q[w][lk_set] | (lk_laddr & ~msk_q[w][lk_set]);
      end
    end
  end

  always_comb begin
    logic       got;
    logic [7:0] best;
    got  = 1'b0;
    vic  = '0;
    best = sc_q[0][up_set];
    for (int w = 0; w < WAYS; w++) begin
      if (!got && !v_q[w][up_set]) begin
        vic = WW'(w);
        got = 1'b1;
      end
    end
    if (!got) begin
      for (int w = 1; w < WAYS; w++) begin
        if (sc_q[w][up_set] < best) begin
          best = sc_q[w][up_set];
          vic  = WW'(w);
        end
      end
    end
  end

  always_comb begin
    logic          gn;
    logic [AW-1:0] tn, mn;
    for (int w = 0; w < WAYS; w++) begin
      for (int s = 0; s < SETS; s++) begin
        fill_e[w][s] = up_valid && (up_set == IW'(s)) && (vic == WW'(w));
        bump_e[w][s] = lk_valid && hit_any && (lk_set == IW'(s)) &&
                       (hit_way == WW'(w)) && !fill_e[w][s];
        gn = fill_e[w][s] ? up_global : g_q[w][s];
        tn = fill_e[w][s] ? (up_laddr & up_mask) : tag_q[w][s];
        mn = fill_e[w][s] ? up_mask : msk_q[w][s];
        drop_e[w][s] = fl_all || (fl_nonglobal && !gn) ||
                       (inv_valid && (inv_set == IW'(s)) && ((inv_laddr & mn) == tn));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          v_q[w][s]    <= 1'b0;
          g_q[w][s]    <= 1'b0;
          sc_q[w][s]   <= '0;
          tag_q[w][s]  <= '0;
          msk_q[w][s]  <= '0;
          base_q[w][s] <= '0;
        end
      end
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          if (fill_e[w][s]) begin
            v_q[w][s]    <= 1'b1;
            g_q[w][s]    <= up_global;
            sc_q[w][s]   <= '0;
            tag_q[w][s]  <= up_laddr & up_mask;
            msk_q[w][s]  <= up_mask;
            base_q[w][s] <= up_paddr & up_mask;
          end else if (bump_e[w][s] && sc_q[w][s] != SC_MAX) begin
            sc_q[w][s] <= sc_q[w][s] + 8'd1;
          end
          if (drop_e[w][s]) v_q[w][s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lookup       <= '0;
      cnt_hit          <= '0;
      cnt_miss         <= '0;
      cnt_update       <= '0;
      cnt_fl_all       <= '0;
      cnt_fl_nonglobal <= '0;
      cnt_inv          <= '0;
    end else begin
      if (lk_valid)            cnt_lookup       <= cnt_lookup + CW'(1);
      if (lk_valid && hit_any) cnt_hit          <= cnt_hit + CW'(1);
      if (lk_valid && !hit_any) cnt_miss        <= cnt_miss + CW'(1);
      if (up_valid)            cnt_update       <= cnt_update + CW'(1);
      if (fl_all)              cnt_fl_all       <= cnt_fl_all + CW'(1);
      if (fl_nonglobal)        cnt_fl_nonglobal <= cnt_fl_nonglobal + CW'(1);
      if (inv_valid)           cnt_inv          <= cnt_inv + CW'(1);
    end
  end

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_chk_w
    for (genvar gs = 0; gs < SETS; gs++) begin : g_chk_s
      p_score_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_e[gw][gs] |=> sc_q[gw][gs] >= $past(sc_q[gw][gs]));
      p_fill_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_e[gw][gs] |=> sc_q[gw][gs] == 8'd0);
    end
  end

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> !lk_hit);

  p_inv_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_hit && lk_laddr == $past(inv_laddr)));

  p_cnt_split_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lookup == cnt_hit + cnt_miss);

  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> cnt_lookup == $past(cnt_lookup) + CW'(1));
endmodule

// File: tb/score_tlb_tb.sv
`timescale 1ns/1ps
module score_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, up_valid, up_global, fl_all, fl_nonglobal, inv_valid;
  logic [31:0] lk_laddr, up_laddr, up_paddr, inv_laddr, lk_paddr;
  logic [1:0]  up_size;
  logic        lk_hit;
  logic [63:0] cnt_lookup, cnt_hit, cnt_miss, cnt_update, cnt_fl_all, cnt_fl_nonglobal, cnt_inv;

  int total = 0;
  int bad   = 0;
  logic [63:0] e_look = 0, e_hit = 0, e_miss = 0, e_upd = 0, e_fa = 0, e_fn = 0, e_inv = 0;

  bit          q_hit[$];
  logic [31:0] q_pa[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  score_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_laddr(lk_laddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .up_valid(up_valid), .up_laddr(up_laddr), .up_paddr(up_paddr), .up_size(up_size),
    .up_global(up_global), .fl_all(fl_all), .fl_nonglobal(fl_nonglobal),
    .inv_valid(inv_valid), .inv_laddr(inv_laddr),
    .cnt_lookup(cnt_lookup), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_update(cnt_update),
    .cnt_fl_all(cnt_fl_all), .cnt_fl_nonglobal(cnt_fl_nonglobal), .cnt_inv(cnt_inv)
  );

  task automatic idle();
    lk_valid = 0; up_valid = 0; up_global = 0; fl_all = 0; fl_nonglobal = 0; inv_valid = 0;
    lk_laddr = '0; up_laddr = '0; up_paddr = '0; up_size = '0; inv_laddr = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic arm_look(input logic [31:0] a, input bit eh, input logic [31:0] ep, input string tg);
    lk_valid = 1; lk_laddr = a;
    q_hit.push_back(eh); q_pa.push_back(ep); q_tag.push_back(tg);
    e_look++;
    if (eh) e_hit++; else e_miss++;
  endtask

  task automatic look(input logic [31:0] a, input bit eh, input logic [31:0] ep, input string tg);
    arm_look(a, eh, ep, tg);
    step();
  endtask

  task automatic arm_fill(input logic [31:0] la, input logic [31:0] pa, input logic [1:0] sz, input bit g);
    up_valid = 1; up_laddr = la; up_paddr = pa; up_size = sz; up_global = g;
    e_upd++;
  endtask

  task automatic fill(input logic [31:0] la, input logic [31:0] pa, input logic [1:0] sz, input bit g);
    arm_fill(la, pa, sz, g);
    step();
  endtask

  task automatic arm_inv(input logic [31:0] a);
    inv_valid = 1; inv_laddr = a; e_inv++;
  endtask

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  // monitor: pops one expectation per lookup cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1 && lk_valid === 1'b1) begin
      total++;
      if (q_hit.size() == 0) begin
        bad++;
        $display("FAIL R1: lookup with no expectation, actual hit=%0b expected none", lk_hit);
      end else begin
        bit          h;
        logic [31:0] p;
        string       t;
        h = q_hit.pop_front(); p = q_pa.pop_front(); t = q_tag.pop_front();
        if (lk_hit !== h || (h && lk_paddr !== p)) begin
          bad++;
          $display("FAIL %s: actual hit=%0b pa=%h expected hit=%0b pa=%h", t, lk_hit, lk_paddr, h, p);
        end
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R12 lookup count at reset", cnt_lookup, 0);
    chk("R12 update count at reset", cnt_update, 0);
    rst_n = 1;
    look(32'h0010_0000, 0, 0, "R12 empty after reset");

    // set 0: invalid-first fill, then score victims (R4 R5 R6)
    fill(32'h0010_0000, 32'h0A00_0ABC, 0, 0);
    fill(32'h0011_0000, 32'h0A01_0000, 0, 0);
    fill(32'h0012_0000, 32'h0A02_0000, 0, 0);
    fill(32'h0013_0000, 32'h0A03_0000, 0, 0);
    look(32'h0010_0123, 1, 32'h0A00_0123, "R2 base with offset");
    look(32'h0010_0000, 1, 32'h0A00_0000, "R4 way0 filled");
    look(32'h0011_0004, 1, 32'h0A01_0004, "R4 way1 filled");
    look(32'h0011_0004, 1, 32'h0A01_0004, "R1 repeat hit");
    look(32'h0012_07FF, 1, 32'h0A02_07FF, "R4 way2 filled");
    look(32'h0013_0FFF, 1, 32'h0A03_0FFF, "R4 way3 filled");
    fill(32'h0014_0000, 32'h0A04_0000, 0, 0);
    fill(32'h0015_0000, 32'h0A05_0000, 0, 0);
    look(32'h0013_0000, 1, 32'h0A03_0000, "R5 higher way at tie kept");
    look(32'h0012_0000, 0, 0, "R5 tie evicts lowest way");
    look(32'h0014_0000, 0, 0, "R6 fresh fill has score 0");
    look(32'h0015_0010, 1, 32'h0A05_0010, "R5 newest fill present");
    look(32'h0010_0000, 1, 32'h0A00_0000, "R5 busy entry kept");

    // set 1: saturation (R6)
    for (int k = 0; k < 4; k++) fill(32'h0020_1000 + k * 32'h1_0000, 32'h0B00_0000 + k * 32'h1000, 0, 0);
    for (int i = 0; i < 256; i++) look(32'h0020_1000, 1, 32'h0B00_0000, "R6 repeated hits");
    for (int k = 1; k < 4; k++) look(32'h0020_1000 + k * 32'h1_0000, 1, 32'h0B00_0000 + k * 32'h1000, "R6 single hit");
    fill(32'h0024_1000, 32'h0B00_4000, 0, 0);
    look(32'h0020_1000, 1, 32'h0B00_0000, "R6 score saturates, no wrap");
    look(32'h0021_1000, 0, 0, "R6 lowest score evicted");
    look(32'h0024_1000, 1, 32'h0B00_4000, "R6 new entry present");

    // page sizes (R3)
    fill(32'h1060_5000, 32'h0820_0000, 1, 0);
    look(32'h107A_5123, 1, 32'h083A_5123, "R3 2MB hit");
    look(32'h1080_5000, 0, 0, "R3 outside 2MB miss");
    fill(32'h2000_6000, 32'h0C00_0000, 2, 0);
    look(32'h2031_6ABC, 1, 32'h0C31_6ABC, "R3 4MB hit");
    look(32'h2040_6000, 0, 0, "R3 outside 4MB miss");
    fill(32'h3000_A000, 32'h0500_0000, 3, 0);
    look(32'h3000_AFFF, 1, 32'h0500_0FFF, "R3 code 3 is 4KB");
    look(32'h3010_A000, 0, 0, "R3 code 3 other page miss");

    // set 9: lookup and fill in the same cycle (R10)
    for (int k = 0; k < 4; k++) fill(32'h0040_9000 + k * 32'h1_0000, 32'h0D00_0000 + k * 32'h1000, 0, 0);
    for (int k = 0; k < 3; k++) look(32'h0040_9000 + k * 32'h1_0000, 1, 32'h0D00_0000 + k * 32'h1000, "R10 setup hit");
    arm_look(32'h0043_9000, 1, 32'h0D00_3000, "R10 lookup sees old contents");
    arm_fill(32'h0050_9000, 32'h0E00_0000, 0, 0);
    step();
    fill(32'h0051_9000, 32'h0E10_0000, 0, 0);
    look(32'h0050_9000, 0, 0, "R10 hit increment dropped on victim");
    look(32'h0051_9000, 1, 32'h0E10_0000, "R10 second fill present");
    look(32'h0043_9000, 0, 0, "R10 old entry replaced");
    look(32'h0040_9000, 1, 32'h0D00_0000, "R10 way0 untouched");

    // set 7: global and non-global
    fill(32'h0060_7000, 32'h0F00_0000, 0, 1);
    fill(32'h0061_7000, 32'h0F10_0000, 0, 0);

    // set 8: page invalidate (R9)
    fill(32'h0070_8000, 32'h0710_0000, 0, 0);
    fill(32'h0071_8000, 32'h0720_0000, 0, 0);
    fill(32'h0072_8000, 32'h0730_0000, 0, 1);
    arm_inv(32'h0070_8044); step();
    look(32'h0070_8000, 0, 0, "R9 invalidated page miss");
    look(32'h0071_8000, 1, 32'h0720_0000, "R9 neighbour kept");
    arm_inv(32'h0072_8000); step();
    look(32'h0072_8000, 0, 0, "R9 global page invalidated");
    arm_fill(32'h0073_8000, 32'h0740_0000, 0, 0);
    arm_inv(32'h0073_8000);
    step();
    look(32'h0073_8000, 0, 0, "R9 invalidate beats same-cycle fill");

    // non-global flush (R8)
    fl_nonglobal = 1; e_fn++; step();
    look(32'h0060_7000, 1, 32'h0F00_0000, "R8 global kept");
    look(32'h0061_7000, 0, 0, "R8 non-global gone");
    look(32'h0015_0000, 0, 0, "R8 4KB non-global gone");
    look(32'h1070_5000, 0, 0, "R8 2MB non-global gone");

    // full flush racing a fill (R7)
    fl_all = 1; e_fa++;
    arm_fill(32'h0080_3000, 32'h0900_0000, 0, 1);
    step();
    look(32'h0060_7000, 0, 0, "R7 global gone after full flush");
    look(32'h0080_3000, 0, 0, "R7 same-cycle fill flushed");

    step();
    chk("R11 lookup count", cnt_lookup, e_look);
    chk("R11 hit count", cnt_hit, e_hit);
    chk("R11 miss count", cnt_miss, e_miss);
    chk("R11 update count", cnt_update, e_upd);
    chk("R11 full flush count", cnt_fl_all, e_fa);
    chk("R11 non-global flush count", cnt_fl_nonglobal, e_fn);
    chk("R11 invalidate count", cnt_inv, e_inv);
    chk("R1 expectations drained", q_hit.size(), 0);
    summary();
  end
endmodule